// File: doc/BRIEF.md
# Program/Verify Address Counter and Region Map

This block keeps the word address used while a 12-bit-word microcontroller sits in its serial program/verify mode. A mode-entry pulse starts the counter at the configuration word address (0x3FF). An increment strobe then steps it through the 1024-word space. The first step closes access to the configuration word until the next entry. The counter runs from 0x000 upward, crosses from 0x1FF into the configuration half at 0x200, and wraps from 0x3FF back to 0x000.

Every cycle the current address is decoded into one of five regions: user program memory, user ID words, reserved space, unimplemented space, and the configuration word. Load requests become a write enable for the storage that belongs to the current region, and the 14-bit serial word is trimmed to 12 bits. Read requests return a registered 14-bit word with its two upper bits at zero. Code protection zeroes user-memory reads. Reserved and unimplemented space reads as zero and cannot be written. The storage arrays sit outside the block and are read combinationally.

Top module: `prog_addr_map`

## Requirements
- R1: Exactly one region flag is high in every cycle. User is 0x000–0x1FF, ID is 0x200–0x203, reserved is 0x204–0x23F, and unimplemented is 0x240–0x3FE plus 0x3FF while the configuration word is closed. The configuration flag is set only at 0x3FF while it is open.
- R2: One cycle after a mode-entry pulse, the address is 0x3FF and both the mode flag and the configuration-open flag are high.
- R3: An increment strobe in mode raises the address by one in the next cycle and clears the configuration-open flag, which stays low until the next entry.
- R4: Incrementing from 0x1FF gives 0x200.
- R5: Incrementing from 0x3FF gives 0x000.
- R6: A load in mode raises, in the same cycle, the write enable of the current region (user, ID or configuration). The write data is bits 11:0 of the load word. Reserved and unimplemented regions get no enable.
- R7: A read in mode sets the valid flag for one cycle and updates the read data on the next cycle. Bits 13:12 of the read data are 0 and bits 11:0 are the current region's word. Without a read, the read data holds its value.
- R8: With the protect input low, user-memory reads return zero. Loads to user memory still take effect, and ID and configuration reads are unaffected.
- R9: Reads from reserved or unimplemented addresses return zero.
- R10: Reset or a mode-exit pulse clears the mode and configuration-open flags and sets the address to 0x000. Out of mode, increments, loads and reads have no effect.
- R11: When strobes coincide, exit wins over entry and entry wins over increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_i | input | 1 | Mode-entry pulse |
| exit_i | input | 1 | Mode-exit pulse |
| incr_i | input | 1 | Address increment strobe |
| load_i | input | 1 | Load request for the current address |
| load_data_i | input | 14 | Serial load word |
| read_i | input | 1 | Read request for the current address |
| cp_n_i | input | 1 | Code protect, 0 = protected |
| user_rdata_i | input | 12 | User memory word at the current address |
| id_rdata_i | input | 12 | ID word at the current address |
| cfg_rdata_i | input | 12 | Configuration word |
| addr_o | output | 10 | Current address |
| in_mode_o | output | 1 | Program/verify mode active |
| cfg_open_o | output | 1 | Configuration word still accessible |
| rgn_user_o | output | 1 | Address is in user memory |
| rgn_id_o | output | 1 | Address is an ID word |
| rgn_rsvd_o | output | 1 | Address is reserved |
| rgn_unimpl_o | output | 1 | Address is unimplemented |
| rgn_cfg_o | output | 1 | Address is the open configuration word |
| user_we_o | output | 1 | User memory write enable |
| id_we_o | output | 1 | ID word write enable |
| cfg_we_o | output | 1 | Configuration word write enable |
| wr_data_o | output | 12 | Write data |
| rd_valid_o | output | 1 | Read data updated this cycle |
| rd_data_o | output | 14 | Read data |

## Verification
The bench builds the block with its default parameters: a 10-bit address, 512 user words, 4 ID words and 64 physically present configuration words. Those small sizes let one run walk the counter through every address of the map. The walk covers both crossings (0x1FF to 0x200, and 0x3FF to 0x000) and visits each region boundary, including 0x3FF after the configuration word has closed. Code protection, coinciding strobes and out-of-mode requests are applied at chosen points on that walk.

// File: rtl/pam_pkg.sv
`timescale 1ns/1ps
// Package: shared region type for the program/verify address map.
// Assumes: one region is active for any address.
package pam_pkg;
    typedef enum logic [2:0] {
        RG_USER   = 3'd0,
        RG_ID     = 3'd1,
        RG_RSVD   = 3'd2,
        RG_UNIMPL = 3'd3,
        RG_CFG    = 3'd4
    } region_e;
endpackage

// File: rtl/pam_counter.sv
`timescale 1ns/1ps
// Module: pam_counter
// Holds the word address, the mode flag and the config-open flag.
// Assumes strobes are single-cycle. Priority is exit, then entry, then increment.
module pam_counter #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              incr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              in_mode_o,
    output logic              cfg_open_o
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

    // Next-state update for address and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            in_mode_o  <= 1'b0;
            cfg_open_o <= 1'b0;
        end else if (exit_i) begin
            addr_o     <= '0;
            in_mode_o  <= 1'b0;
            cfg_open_o <= 1'b0;
        end else if (enter_i) begin
            addr_o     <= ADDR_MAX;
            in_mode_o  <= 1'b1;
            cfg_open_o <= 1'b1;
        end else if (incr_i && in_mode_o) begin
            addr_o     <= (addr_o == ADDR_MAX) ? '0 : addr_o + 1'b1;
            cfg_open_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pam_decode.sv
`timescale 1ns/1ps
// Module: pam_decode
// Maps the address and config-open flag onto one region.
// Assumes USER_WORDS + PHYS_WORDS < 2**ADDR_W and ID_WORDS <= PHYS_WORDS.
module pam_decode
    import pam_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int USER_WORDS = 512,
    parameter int ID_WORDS   = 4,
    parameter int PHYS_WORDS = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cfg_open_i,
    output region_e           region_o
);
    localparam int ID_BASE     = USER_WORDS;
    localparam int RSVD_BASE   = ID_BASE + ID_WORDS;
    localparam int UNIMPL_BASE = USER_WORDS + PHYS_WORDS;
    localparam int CFG_ADDR    = (1 << ADDR_W) - 1;

    int a;

    // Range compare of the current address.
    always_comb begin
        a = int'(addr_i);
        if (a < ID_BASE)                      region_o = RG_USER;
        else if (a < RSVD_BASE)               region_o = RG_ID;
        else if (a < UNIMPL_BASE)             region_o = RG_RSVD;
        else if (a == CFG_ADDR && cfg_open_i) region_o = RG_CFG;
        else                                  region_o = RG_UNIMPL;
    end
endmodule

// File: rtl/pam_access.sv
`timescale 1ns/1ps
// Module: pam_access
// Gates loads into per-region write enables and registers masked read data.
// Assumes storage read data is valid combinationally for the current address.
module pam_access
    import pam_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region_i,
    input  logic              in_mode_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              read_i,
    input  logic              cp_n_i,
    input  logic [WORD_W-1:0] user_rdata_i,
    input  logic [WORD_W-1:0] id_rdata_i,
    input  logic [WORD_W-1:0] cfg_rdata_i,
    output logic              user_we_o,
    output logic              id_we_o,
    output logic              cfg_we_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - WORD_W;

    logic              ld_ok;
    logic              rd_ok;
    logic [WORD_W-1:0] rd_sel;

    assign ld_ok     = in_mode_i && load_i;
    assign rd_ok     = in_mode_i && read_i;
    assign wr_data_o = load_data_i[WORD_W-1:0];

    // Write enable for the storage that owns the current region.
    always_comb begin
        user_we_o = ld_ok && (region_i == RG_USER);
        id_we_o   = ld_ok && (region_i == RG_ID);
        cfg_we_o  = ld_ok && (region_i == RG_CFG);
    end

    // Read source select with protection and empty-region zeroing.
    always_comb begin
        case (region_i)
            RG_USER: rd_sel = cp_n_i ? user_rdata_i : '0;
            RG_ID:   rd_sel = id_rdata_i;
            RG_CFG:  rd_sel = cfg_rdata_i;
            default: rd_sel = '0;
        endcase
    end

    // Read data register, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_ok;
            if (rd_ok) rd_data_o <= {{PAD_W{1'b0}}, rd_sel};
        end
    end
endmodule

// File: rtl/prog_addr_map.sv
`timescale 1ns/1ps
// Module: prog_addr_map
// Address counter, region map and access gate for program/verify mode.
// Assumes the storage arrays are external and read combinationally at addr_o.
module prog_addr_map
    import pam_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 12,
    parameter int DATA_W     = 14,
    parameter int USER_WORDS = 512,
    parameter int ID_WORDS   = 4,
    parameter int PHYS_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              incr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              read_i,
    input  logic              cp_n_i,
    input  logic [WORD_W-1:0] user_rdata_i,
    input  logic [WORD_W-1:0] id_rdata_i,
    input  logic [WORD_W-1:0] cfg_rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              in_mode_o,
    output logic              cfg_open_o,
    output logic              rgn_user_o,
    output logic              rgn_id_o,
    output logic              rgn_rsvd_o,
    output logic              rgn_unimpl_o,
    output logic              rgn_cfg_o,
    output logic              user_we_o,
    output logic              id_we_o,
    output logic              cfg_we_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    region_e region;

    pam_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (enter_i),
        .exit_i     (exit_i),
        .incr_i     (incr_i),
        .addr_o     (addr_o),
        .in_mode_o  (in_mode_o),
        .cfg_open_o (cfg_open_o)
    );

    pam_decode #(
        .ADDR_W     (ADDR_W),
        .USER_WORDS (USER_WORDS),
        .ID_WORDS   (ID_WORDS),
        .PHYS_WORDS (PHYS_WORDS)
    ) u_dec (
        .addr_i     (addr_o),
        .cfg_open_i (cfg_open_o),
        .region_o   (region)
    );

    pam_access #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .region_i     (region),
        .in_mode_i    (in_mode_o),
        .load_i       (load_i),
        .load_data_i  (load_data_i),
        .read_i       (read_i),
        .cp_n_i       (cp_n_i),
        .user_rdata_i (user_rdata_i),
        .id_rdata_i   (id_rdata_i),
        .cfg_rdata_i  (cfg_rdata_i),
        .user_we_o    (user_we_o),
        .id_we_o      (id_we_o),
        .cfg_we_o     (cfg_we_o),
        .wr_data_o    (wr_data_o),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o)
    );

    // One-hot region flags from the decoded region.
    always_comb begin
        rgn_user_o   = (region == RG_USER);
        rgn_id_o     = (region == RG_ID);
        rgn_rsvd_o   = (region == RG_RSVD);
        rgn_unimpl_o = (region == RG_UNIMPL);
        rgn_cfg_o    = (region == RG_CFG);
    end
endmodule

// File: rtl/pam_checker.sv
`timescale 1ns/1ps
// Module: pam_checker
// Temporal properties of prog_addr_map, attached with bind.
// Assumes default-style widths passed in from the bound instance.
module pam_checker #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 14,
    parameter int WORD_W     = 12,
    parameter int USER_WORDS = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_i,
    input logic              exit_i,
    input logic              incr_i,
    input logic              read_i,
    input logic              cp_n_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              in_mode_o,
    input logic              cfg_open_o,
    input logic              rgn_user_o,
    input logic              rgn_id_o,
    input logic              rgn_rsvd_o,
    input logic              rgn_unimpl_o,
    input logic              rgn_cfg_o,
    input logic              user_we_o,
    input logic              id_we_o,
    input logic              cfg_we_o,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o
);
    localparam logic [ADDR_W-1:0] A_MAX     = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_USR_TOP = ADDR_W'(USER_WORDS - 1);
    localparam logic [ADDR_W-1:0] A_CFG_LO  = ADDR_W'(USER_WORDS);

    p_one_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rgn_user_o, rgn_id_o, rgn_rsvd_o, rgn_unimpl_o, rgn_cfg_o}) == 1);

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i && !exit_i |=> addr_o == A_MAX && cfg_open_o && in_mode_o);

    p_cfg_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        incr_i && in_mode_o && !enter_i && !exit_i |=> !cfg_open_o);

    p_cross_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        incr_i && in_mode_o && !enter_i && !exit_i && addr_o == A_USR_TOP |=> addr_o == A_CFG_LO);

    p_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        incr_i && in_mode_o && !enter_i && !exit_i && addr_o == A_MAX |=> addr_o == '0);

    p_no_write_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_rsvd_o || rgn_unimpl_o) |-> !(user_we_o || id_we_o || cfg_we_o));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> rd_data_o[DATA_W-1:WORD_W] == '0);

    p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_mode_o && read_i && !cp_n_i && rgn_user_o |=> rd_data_o == '0);

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_mode_o && read_i && (rgn_rsvd_o || rgn_unimpl_o) |=> rd_data_o == '0);

    p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_i |=> !in_mode_o && !cfg_open_o && addr_o == '0);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_mode_o |-> !(user_we_o || id_we_o || cfg_we_o) && !cfg_open_o);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_mode_o && !enter_i && !exit_i |=> $stable(addr_o) && !rd_valid_o);
endmodule

bind prog_addr_map pam_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WORD_W     (WORD_W),
    .USER_WORDS (USER_WORDS)
) u_pam_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_i      (enter_i),
    .exit_i       (exit_i),
    .incr_i       (incr_i),
    .read_i       (read_i),
    .cp_n_i       (cp_n_i),
    .addr_o       (addr_o),
    .in_mode_o    (in_mode_o),
    .cfg_open_o   (cfg_open_o),
    .rgn_user_o   (rgn_user_o),
    .rgn_id_o     (rgn_id_o),
    .rgn_rsvd_o   (rgn_rsvd_o),
    .rgn_unimpl_o (rgn_unimpl_o),
    .rgn_cfg_o    (rgn_cfg_o),
    .user_we_o    (user_we_o),
    .id_we_o      (id_we_o),
    .cfg_we_o     (cfg_we_o),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
);

// File: tb/tb_prog_addr_map.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design on every clock.
module tb_prog_addr_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter = 1'b0, exitm = 1'b0, incr = 1'b0, load = 1'b0, read = 1'b0;
    logic        cp_n = 1'b1;
    logic [13:0] ldata = '0;
    logic [11:0] urd, ird, crd;
    logic [9:0]  addr;
    logic        in_mode, cfg_open, g_user, g_id, g_rsvd, g_unimpl, g_cfg;
    logic        uwe, iwe, cwe, rvalid;
    logic [11:0] wdata;
    logic [13:0] rdata;

    always #10 clk = ~clk;

    prog_addr_map dut (
        .clk(clk), .rst_n(rst_n), .enter_i(enter), .exit_i(exitm), .incr_i(incr),
        .load_i(load), .load_data_i(ldata), .read_i(read), .cp_n_i(cp_n),
        .user_rdata_i(urd), .id_rdata_i(ird), .cfg_rdata_i(crd),
        .addr_o(addr), .in_mode_o(in_mode), .cfg_open_o(cfg_open),
        .rgn_user_o(g_user), .rgn_id_o(g_id), .rgn_rsvd_o(g_rsvd),
        .rgn_unimpl_o(g_unimpl), .rgn_cfg_o(g_cfg),
        .user_we_o(uwe), .id_we_o(iwe), .cfg_we_o(cwe), .wr_data_o(wdata),
        .rd_valid_o(rvalid), .rd_data_o(rdata)
    );

    // Storage arrays driven by the design's enables.
    logic [11:0] umem [512];
    logic [11:0] imem [4];
    logic [11:0] cmem;
    assign urd = umem[addr[8:0]];
    assign ird = imem[addr[1:0]];
    assign crd = cmem;
    always @(posedge clk) begin
        if (uwe) umem[addr[8:0]] <= wdata;
        if (iwe) imem[addr[1:0]] <= wdata;
        if (cwe) cmem <= wdata;
    end

    // Reference model state.
    int m_addr, m_mode, m_open, m_rv, m_rd;
    int mu [512];
    int mi [4];
    int mc;
    int vectors = 0, fails = 0;
    bit started = 0;
    string phase = "R10";

    function automatic int rgn(input int a, input int op);
        if (a < 512) return 0;
        if (a < 516) return 1;
        if (a < 576) return 2;
        if (a == 1023 && op != 0) return 4;
        return 3;
    endfunction

    initial begin
        for (int i = 0; i < 512; i++) begin
            umem[i] = 12'((i * 37) ^ 12'h5A5);
            mu[i]   = (i * 37 % 4096) ^ 'h5A5;
        end
        for (int i = 0; i < 4; i++) begin
            imem[i] = 12'(12'h8C0 + i);
            mi[i]   = 'h8C0 + i;
        end
        cmem = 12'hABC;
        mc   = 'hABC;
    end

    // Model step: read before write, then counter update.
    always @(posedge clk) begin
        int r;
        started = 1;
        if (!rst_n) begin
            m_addr = 0; m_mode = 0; m_open = 0; m_rv = 0; m_rd = 0;
        end else begin
            r = rgn(m_addr, m_open);
            m_rv = (m_mode != 0 && read) ? 1 : 0;
            if (m_rv != 0) begin
                case (r)
                    0: m_rd = cp_n ? mu[m_addr] : 0;
                    1: m_rd = mi[m_addr - 512];
                    4: m_rd = mc;
                    default: m_rd = 0;
                endcase
            end
            if (m_mode != 0 && load) begin
                if (r == 0) mu[m_addr] = int'(ldata[11:0]);
                if (r == 1) mi[m_addr - 512] = int'(ldata[11:0]);
                if (r == 4) mc = int'(ldata[11:0]);
            end
            if (exitm) begin
                m_addr = 0; m_mode = 0; m_open = 0;
            end else if (enter) begin
                m_addr = 1023; m_mode = 1; m_open = 1;
            end else if (incr && m_mode != 0) begin
                m_addr = (m_addr + 1) % 1024; m_open = 0;
            end
        end
    end

    task automatic chk(input string sig, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (addr model %0h)", phase, sig, act, exp, m_addr);
        end
    endtask

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        int r;
        if (started) begin
            r = rgn(m_addr, m_open);
            chk("addr", int'(addr), m_addr);
            chk("in_mode", int'(in_mode), m_mode);
            chk("cfg_open", int'(cfg_open), m_open);
            chk("regions", int'({g_cfg, g_unimpl, g_rsvd, g_id, g_user}), 1 << r);
            chk("user_we", int'(uwe), (m_mode != 0 && load && r == 0) ? 1 : 0);
            chk("id_we", int'(iwe), (m_mode != 0 && load && r == 1) ? 1 : 0);
            chk("cfg_we", int'(cwe), (m_mode != 0 && load && r == 4) ? 1 : 0);
            chk("wr_data", int'(wdata), int'(ldata) % 4096);
            chk("rd_valid", int'(rvalid), m_rv);
            chk("rd_data", int'(rdata), m_rd);
        end
    end

    task automatic op(input bit en, input bit ex, input bit inc, input bit ld, input bit rd,
                      input logic [13:0] d);
        @(negedge clk);
        #2;
        enter = en; exitm = ex; incr = inc; load = ld; read = rd; ldata = d;
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 14'h0);
    endtask

    task automatic step_to(input int target);
        for (int k = 0; k < 1100 && m_addr != target; k++) begin
            op(0, 0, 1, 0, 0, 14'h0);
            @(posedge clk);
        end
        idle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        idle();
        // R2: entry lands on the configuration word
        phase = "R2";
        op(1, 0, 0, 0, 0, 14'h0);
        op(0, 0, 0, 0, 1, 14'h0);
        // R6: load trims 14 bits to 12
        phase = "R6";
        op(0, 0, 0, 1, 0, 14'h3F5A);
        op(0, 0, 0, 0, 1, 14'h0);
        idle();
        // R11: entry beats increment
        phase = "R11";
        op(1, 0, 1, 0, 0, 14'h0);
        idle();
        // R3: increment closes config access
        phase = "R3";
        op(0, 0, 1, 0, 0, 14'h0);
        for (int i = 0; i < 8; i++) begin
            phase = "R7";
            op(0, 0, 0, 1, 1, 14'h2000 | 14'(i * 291));
            op(0, 0, 0, 0, 1, 14'h0);
            op(0, 0, 1, 0, 0, 14'h0);
        end
        // R8: protection zeroes user reads, writes still land
        phase = "R8";
        cp_n = 1'b0;
        op(0, 0, 0, 0, 1, 14'h0);
        op(0, 0, 0, 1, 0, 14'h0777);
        op(0, 0, 0, 0, 1, 14'h0);
        idle();
        cp_n = 1'b1;
        op(0, 0, 0, 0, 1, 14'h0);
        idle();
        // R4: cross from user memory into configuration space
        phase = "R4";
        step_to(511);
        op(0, 0, 0, 0, 1, 14'h0);
        op(0, 0, 1, 0, 0, 14'h0);
        idle();
        // R8: ID words read normally under protection
        phase = "R8";
        cp_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            op(0, 0, 0, 0, 1, 14'h0);
            op(0, 0, 0, 1, 0, 14'h1F0 + 14'(i));
            op(0, 0, 0, 0, 1, 14'h0);
            op(0, 0, 1, 0, 0, 14'h0);
        end
        // R9: reserved and unimplemented reads are zero, loads dropped
        phase = "R9";
        idle();
        op(0, 0, 0, 1, 1, 14'h0FFF);
        op(0, 0, 0, 0, 1, 14'h0);
        step_to(575);
        op(0, 0, 0, 1, 1, 14'h0FFF);
        op(0, 0, 1, 0, 0, 14'h0);
        op(0, 0, 0, 1, 1, 14'h0FFF);
        step_to(1023);
        op(0, 0, 0, 1, 1, 14'h0FFF);
        op(0, 0, 0, 0, 1, 14'h0);
        // R5: wrap to zero
        phase = "R5";
        cp_n = 1'b1;
        op(0, 0, 1, 0, 0, 14'h0);
        op(0, 0, 0, 0, 1, 14'h0);
        idle();
        // R10: exit beats entry, then requests are ignored
        phase = "R10";
        op(1, 1, 0, 0, 0, 14'h0);
        op(0, 0, 1, 1, 1, 14'h0ABC);
        op(0, 0, 1, 1, 1, 14'h0ABC);
        idle();
        // R1: configuration word reachable again after re-entry
        phase = "R1";
        op(1, 0, 0, 0, 0, 14'h0);
        op(0, 0, 0, 0, 1, 14'h0);
        idle();
        idle();
        finish_run();
    end
endmodule